// File: doc/BRIEF.md
# Seventh-Order Single-Bit Delta-Sigma Modulator

This block turns a stream of signed audio samples into a one-bit stream for a DAC. Each accepted sample advances a loop of seven cascaded fixed-point integrators by one step. Each integrator is fed by the stage before it. The single output bit is fed back into every stage. Three local resonator paths pull from a later stage back into an earlier one. The output bit of a step is the sign decision taken on the freshly updated last state. That bit is fed back on the following step. There is no dither.

To keep the loop stable under overdrive, the first six states are each held inside their own symmetric window. Every time a window bites, an event is counted. A second counter records steps where the raw decision of the last stage fell outside the ±1 range and had to be forced. Both counters stop at their maximum value and can be read at any time. All coefficients, gains, limits and widths are parameters. The states use a common binary point of `FRAC` fractional bits, and each sample enters stage 1 after an arithmetic right shift by `IN_SHIFT`.

Top module: `ds7_modulator`

## Requirements
- R1: After reset (active-low `rstN`), all seven states are zero, `bitOut` is 0 and both counters read 0.
- R2: On each clock with `sampleEn` high, every stage updates from values of the previous step. The update is the stage input, minus the feedback term, minus the resonator term, plus (own previous state × gain)/32 with arithmetic shift. Stage 1's input is `sampleIn` shifted right arithmetically by `IN_SHIFT`, and stage k's input is the previous state of stage k-1. The gains are 1 everywhere except stage 5 (35/32) and stage 6 (-34/32).
- R3: The feedback term of stage k is its coefficient times the previous output (+1 or -1). On the first step after reset, the feedback weight is 0.
- R4: The resonator terms are (coefficient × previous state)/2^FRAC with arithmetic shift: stage 1 subtracts the term on stage 2's state, stage 3 the term on stage 4's state, and stage 5 the term on stage 6's state.
- R5: States of stages 1 to 6 are limited to ±their own limit after each update. The clamp counter rises by the number of stages limited in that step. Stage 7 is never limited and wraps at `W` bits.
- R6: The rounded last state is r = floor(s7/2^FRAC + 1/2). `bitOut` becomes 1 (meaning +1) when r ≥ 1 and 0 (meaning -1) otherwise, one clock after the accepting edge.
- R7: The saturation counter rises by one on each step where 2r-1 lies outside ±1, that is r ≥ 2 or r ≤ -1.
- R8: Both counters hold at all ones instead of wrapping.
- R9: With `sampleEn` low, `sampleIn` is ignored and `bitOut` and both counters keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | IN_W | Signed input sample |
| sampleEn | input | 1 | Advances the loop by one step |
| bitOut | output | 1 | Output bit, 1 = +1, 0 = -1 |
| clampCount | output | CNT_W | Saturating count of state limiting events |
| satCount | output | CNT_W | Saturating count of forced output decisions |

## Verification
The hardest behaviour to reach from the ports is the counter saturation of R8, because clamp events only pile up when the loop is driven hard for thousands of steps. The bench narrows the counter width. It then holds the input at full scale for several thousand steps, so that stage 1 alone limits on almost every step. Throughout that run, a bit-exact integer model follows the loop, which also covers the wrap of the unlimited last stage. Random small-signal runs with idle gaps, and a Nyquist-rate alternating pattern, cover the ordinary loop and the ignored-input case.

// File: rtl/ds7_pkg.sv
package ds7_pkg;
  localparam int STAGES = 7;
  localparam int RES_N = 3;
  localparam int HIT_W = $clog2(STAGES);

  // Q(FRAC=32) default loop coefficients
  localparam longint C_DEF [STAGES] = '{64'sd3431, 64'sd176362, 64'sd4161640,
    64'sd60910474, 64'sd987060808, 64'sd1301303961, 64'sd1486740783};
  localparam longint LIM_DEF [STAGES] = '{64'sd120263, 64'sd3163981, 64'sd51392693,
    64'sd543070667, 64'sd4753499018, 64'sd4125787720, 64'sd0};
  localparam longint RES_DEF [RES_N] = '{64'sd33554, 64'sd331401, 64'sd0};
  // gains in units of 1/32
  localparam int GAIN_DEF [STAGES] = '{32, 32, 32, 32, 35, -34, 32};

  typedef struct packed {
    logic step;
    logic fbPos;
    logic fbNeg;
  } ds7_strobe_t;

  typedef struct packed {
    logic bitPos;
    logic satHit;
    logic [HIT_W-1:0] clampNum;
  } ds7_status_t;
endpackage

// File: rtl/ds7_loop.sv
module ds7_loop
  import ds7_pkg::*;
#(
  parameter int IN_W = 24,
  parameter int W = 40,
  parameter int FRAC = 32,
  parameter int IN_SHIFT = 11,
  parameter int GAIN_W = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COEF_W = 36,
  parameter int GUARD = 8,
  parameter longint C_COEF [STAGES] = C_DEF,
  parameter longint LIMIT [STAGES] = LIM_DEF,
  parameter longint RES [RES_N] = RES_DEF,
  parameter int GAIN [STAGES] = GAIN_DEF
) (
  input  logic clk,
  input  logic rstN,
  input  logic signed [IN_W-1:0] sampleIn,
  input  ds7_strobe_t strobe,
  output ds7_status_t status
);
  localparam int SUM_W = W + GUARD;
  localparam int PROD_W = W + COEF_W;
  localparam int GP_W = W + GAIN_W;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(64'sd1 <<< (FRAC - 1));

  logic signed [W-1:0] stateQ [STAGES];
  logic signed [W-1:0] stateD [STAGES];
  logic [STAGES-2:0] clampHit;
  logic signed [SUM_W-1:0] xScaled;
  logic signed [SUM_W-1:0] rounded;

  assign xScaled = SUM_W'(sampleIn) >>> IN_SHIFT;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam logic signed [SUM_W-1:0] CK = SUM_W'(C_COEF[k]);
    logic signed [SUM_W-1:0] feedIn, fbTerm, gainTerm, resTerm, rawSum;
    logic signed [GP_W-1:0] gainProd;
    logic signed [W-1:0] stageQ, stageNext;

    if (k == 0) begin : g_first
      assign feedIn = xScaled;
    end else begin : g_chain
      assign feedIn = SUM_W'(stateQ[k-1]);
    end

    assign fbTerm = strobe.fbPos ? CK : (strobe.fbNeg ? -CK : '0);
    assign gainProd = GP_W'(stageQ) * GP_W'(GAIN[k]);
    assign gainTerm = SUM_W'(gainProd >>> GAIN_FRAC);

    if ((k % 2 == 0) && (k < STAGES - 1)) begin : g_res
      logic signed [PROD_W-1:0] resProd;
      assign resProd = PROD_W'(stateQ[k+1]) * PROD_W'(RES[k/2]);
      assign resTerm = SUM_W'(resProd >>> FRAC);
    end else begin : g_nores
      assign resTerm = '0;
    end

    assign rawSum = feedIn - fbTerm - resTerm + gainTerm;

    if (k < STAGES - 1) begin : g_clamp
      localparam logic signed [SUM_W-1:0] LK = SUM_W'(LIMIT[k]);
      logic hitK;
      always_comb begin
        hitK = 1'b0;
        stageNext = W'(rawSum);
        if (rawSum > LK) begin
          stageNext = W'(LK);
          hitK = 1'b1;
        end else if (rawSum < -LK) begin
          stageNext = W'(-LK);
          hitK = 1'b1;
        end
      end
      assign clampHit[k] = hitK;

      // R5: a limited state never leaves its window
      a_r5_within_limit: assert property (@(posedge clk) disable iff (!rstN)
        (SUM_W'(stageQ) <= LK) && (SUM_W'(stageQ) >= -LK));
    end else begin : g_free
      assign stageNext = W'(rawSum);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= '0;
      else if (strobe.step) stageQ <= stageNext;
    end

    assign stateQ[k] = stageQ;
    assign stateD[k] = stageNext;
  end

  assign rounded = (SUM_W'(stateD[STAGES-1]) + HALF) >>> FRAC;

  always_comb begin
    status.bitPos = rounded > 0;
    status.satHit = (rounded > 1) || (rounded < 0);
    status.clampNum = HIT_W'($countones(clampHit));
  end
endmodule

// File: rtl/ds7_ctrl.sv
module ds7_ctrl
  import ds7_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleEn,
  input  ds7_status_t status,
  output ds7_strobe_t strobe,
  output logic bitOut,
  output logic [CNT_W-1:0] clampCount,
  output logic [CNT_W-1:0] satCount
);
  logic fbValid;

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] base,
                                              input logic [HIT_W-1:0] inc);
    logic [CNT_W:0] wide;
    wide = {1'b0, base} + (CNT_W + 1)'(inc);
    return wide[CNT_W] ? '1 : wide[CNT_W-1:0];
  endfunction

  always_comb begin
    strobe.step = sampleEn;
    strobe.fbPos = fbValid && bitOut;
    strobe.fbNeg = fbValid && !bitOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbValid <= 1'b0;
      bitOut <= 1'b0;
      clampCount <= '0;
      satCount <= '0;
    end else if (sampleEn) begin
      fbValid <= 1'b1;
      bitOut <= status.bitPos;
      clampCount <= satAdd(clampCount, status.clampNum);
      satCount <= satAdd(satCount, HIT_W'(status.satHit));
    end
  end

  // R9: idle clocks change nothing visible
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(bitOut) && $stable(clampCount) && $stable(satCount));
  // R8: a full counter stays full
  a_r8_clamp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (&clampCount) |=> (&clampCount));
  a_r8_sat_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (&satCount) |=> (&satCount));
  // R7: a flagged step below the ceiling moves the saturation counter
  a_r7_sat_counted: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && status.satHit && !(&satCount)) |=> (satCount != $past(satCount)));
endmodule

// File: rtl/ds7_modulator.sv
module ds7_modulator
  import ds7_pkg::*;
#(
  parameter int IN_W = 24,
  parameter int W = 40,
  parameter int FRAC = 32,
  parameter int IN_SHIFT = 11,
  parameter int GAIN_W = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COEF_W = 36,
  parameter int GUARD = 8,
  parameter int CNT_W = 16,
  parameter longint C_COEF [STAGES] = C_DEF,
  parameter longint LIMIT [STAGES] = LIM_DEF,
  parameter longint RES [RES_N] = RES_DEF,
  parameter int GAIN [STAGES] = GAIN_DEF
) (
  input  logic clk,
  input  logic rstN,
  input  logic signed [IN_W-1:0] sampleIn,
  input  logic sampleEn,
  output logic bitOut,
  output logic [CNT_W-1:0] clampCount,
  output logic [CNT_W-1:0] satCount
);
  ds7_strobe_t strobe;
  ds7_status_t status;

  ds7_loop #(
    .IN_W(IN_W), .W(W), .FRAC(FRAC), .IN_SHIFT(IN_SHIFT), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .COEF_W(COEF_W), .GUARD(GUARD),
    .C_COEF(C_COEF), .LIMIT(LIMIT), .RES(RES), .GAIN(GAIN)
  ) u_loop (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobe(strobe), .status(status)
  );

  ds7_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .status(status), .strobe(strobe),
    .bitOut(bitOut), .clampCount(clampCount), .satCount(satCount)
  );
endmodule

// File: tb/ds7_modulator_bench.sv
module ds7_modulator_bench;
  localparam int CW = 12;
  localparam int CMAX = (1 << CW) - 1;
  localparam int SHIFT = 11;
  localparam int FULL = (1 << 23) - 1;
  localparam longint CT [7] = '{64'sd3431, 64'sd176362, 64'sd4161640, 64'sd60910474,
    64'sd987060808, 64'sd1301303961, 64'sd1486740783};
  localparam longint LT [7] = '{64'sd120263, 64'sd3163981, 64'sd51392693,
    64'sd543070667, 64'sd4753499018, 64'sd4125787720, 64'sd0};
  localparam longint DT [3] = '{64'sd33554, 64'sd331401, 64'sd0};
  localparam longint GT [7] = '{64'sd32, 64'sd32, 64'sd32, 64'sd32, 64'sd35, -64'sd34, 64'sd32};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [23:0] sampleIn = '0;
  logic sampleEn = 1'b0;
  logic bitOut;
  logic [CW-1:0] clampCount, satCount;

  always #4 clk = ~clk;

  ds7_modulator #(.CNT_W(CW)) u_ds7_modulator (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleEn(sampleEn),
    .bitOut(bitOut), .clampCount(clampCount), .satCount(satCount)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint ms [7];
  int mFb;
  bit mBit;
  int mClamp, mSat;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int capAdd(input int base, input int inc);
    return (base + inc > CMAX) ? CMAX : base + inc;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 7; k++) ms[k] = 0;
    mFb = 0; mBit = 1'b0; mClamp = 0; mSat = 0;
  endtask

  task automatic modelStep(input int smp);
    longint nx [7];
    longint v, r;
    int hits = 0;
    for (int k = 0; k < 7; k++) begin
      v = (k == 0) ? (longint'(smp) >>> SHIFT) : ms[k-1];
      v = v - longint'(mFb) * CT[k] + ((ms[k] * GT[k]) >>> 5);
      if (k == 0 || k == 2 || k == 4) v = v - ((DT[k/2] * ms[k+1]) >>> 32);
      if (k < 6) begin
        if (v > LT[k]) begin v = LT[k]; hits++; end
        else if (v < -LT[k]) begin v = -LT[k]; hits++; end
      end else begin
        v = (v <<< 24) >>> 24;
      end
      nx[k] = v;
    end
    for (int k = 0; k < 7; k++) ms[k] = nx[k];
    r = (nx[6] + (64'sd1 <<< 31)) >>> 32;
    mBit = (r >= 1);
    if (r >= 2 || r <= -1) mSat = capAdd(mSat, 1);
    mClamp = capAdd(mClamp, hits);
    mFb = mBit ? 1 : -1;
  endtask

  task automatic compareAll(input string tag);
    chk(bitOut == mBit, {tag, " R6 bit"}, longint'(bitOut), longint'(mBit));
    chk(int'(clampCount) == mClamp, {tag, " R5 clamp count"}, longint'(clampCount), mClamp);
    chk(int'(satCount) == mSat, {tag, " R7 sat count"}, longint'(satCount), mSat);
  endtask

  task automatic step(input int smp, input int gap, input string tag);
    @(negedge clk);
    sampleIn = 24'(smp);
    sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
    modelStep(smp);
    compareAll(tag);
    for (int g = 0; g < gap; g++) begin
      sampleIn = 24'($urandom);
      @(negedge clk);
    end
    if (gap > 0) compareAll({tag, " R9 idle"});
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    sampleEn = 1'b1;
    sampleIn = 24'(FULL);
    repeat (3) @(negedge clk);
    sampleEn = 1'b0;
    rstN = 1'b1;
    modelReset();
    chk(bitOut == 1'b0, "R1 reset bit", longint'(bitOut), 0);
    chk(clampCount == '0, "R1 reset clamp count", longint'(clampCount), 0);
    chk(satCount == '0, "R1 reset sat count", longint'(satCount), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_d517));
    doReset();
    // R3: first step after reset carries no feedback weight
    step(0, 0, "R3 first step");
    step(0, 1, "R3 second step");
    // R2 R4: directed extremes then random small signals with idle gaps
    step(FULL, 0, "R2 directed");
    step(-FULL - 1, 0, "R2 directed");
    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(0, 1 << 21)) - (1 << 20), int'($urandom_range(0, 2)), "R2 random");
    // R4: alternating Nyquist-rate pattern, small amplitude
    for (int i = 0; i < 200; i++)
      step((i % 2 == 0) ? 40 : -40, 0, "R4 nyquist");
    // R5 R8: sustained overdrive until the counters saturate
    for (int i = 0; i < 5000; i++) step(FULL, 0, "R5 overdrive");
    chk(int'(clampCount) == CMAX, "R8 clamp counter held at max", longint'(clampCount), CMAX);
    for (int i = 0; i < 300; i++) step(-FULL - 1, (i % 50 == 0) ? 3 : 0, "R8 overdrive neg");
    chk(int'(clampCount) == CMAX, "R8 clamp counter stays at max", longint'(clampCount), CMAX);
    // R1: reset in the middle of activity
    doReset();
    step(0, 0, "R3 after reset");
    for (int i = 0; i < 100; i++)
      step(int'($urandom_range(0, 1 << 16)) - (1 << 15), 1, "R2 post reset");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule